// File: doc/BRIEF.md
# Hardware Cursor Overlay Generator

This block lays a small bitmap cursor over a stream of pixels on their way to the display. The host loads two bit-planes into a local map through a pointer/data byte port. One plane is the image and the other is the shape. The host then sets the cursor position, its size (32x32 or 64x64), a 2-bit display mode and three colors: overscan, cursor background and cursor foreground. For each beam coordinate the block decides whether the pixel falls inside the cursor window. It then looks up the two plane bits for that pixel and sends out either the incoming pixel, one of the cursor colors or the inverted incoming pixel. While the blank input is high it sends out the overscan color.

The position is given by the cursor's rightmost column and its bottom scanline. Writes to position, size or mode are held in staging registers and reach the live copy only on a frame-start pulse, so a cursor never tears in the middle of a frame. A two-state machine tracks this. In GEO_SYNCED the live copy equals the staged copy. Any geometry write moves it to GEO_PENDING. It stays in GEO_PENDING until a frame-start cycle with no geometry write in that same cycle, where it commits and returns to GEO_SYNCED. A frame-start that coincides with another geometry write still commits the earlier staged values, but the machine remains in GEO_PENDING.

Top module: `cursor_overlay`

## Requirements
- R1: After reset, out_pix is 0, every color is 0, position is 0, the size is 32 and the mode is off. The first pixel after reset therefore passes under_pix through unchanged.
- R2: host_sel 0 loads the 10-bit map pointer from host_wdata. host_sel 1 stores host_wdata[7:0] at the pointer and then increments the pointer. The pointer wraps from 1023 to 0.
- R3: Map layout for size S: the image plane starts at byte 0 and the shape plane at byte S*S/8 (128 for 32, 512 for 64). Rows are stored top to bottom with S/8 bytes per row. Bit 7 of each byte is the leftmost of its eight pixels.
- R4: The cursor window covers columns xpos-S < x <= xpos and rows ypos-S < y <= ypos. S is 64 when control bit 2 is set and 32 when it is clear. Outside the window the output is under_pix.
- R5: Control bits [1:0] hold the mode. Values 0 and 1 turn the cursor off, and the output is under_pix.
- R6: Mode 2: shape=0 gives under_pix, shape=1 with image=0 gives the background color, and shape=1 with image=1 gives the foreground color.
- R7: Mode 3: shape=0 gives under_pix, shape=1 with image=1 gives the foreground color, and shape=1 with image=0 gives the bitwise inverse of under_pix.
- R8: While blank is high, the output is the overscan color whatever the cursor state.
- R9: host_sel 2 (xpos), 3 (ypos) and 4 (control) update staging registers only. These values take effect at the edge where frame_start is high and are held until the next such edge.
- R10: host_sel 5, 6 and 7 write the overscan, background and foreground colors, and a write takes effect for the very next pixel. out_pix is registered one clock after its beam inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 3 | Host register select |
| host_wdata | input | COLOR_W | Host write data |
| frame_start | input | 1 | One-cycle pulse at the start of a frame |
| beam_x | input | POS_W | Current beam column |
| beam_y | input | POS_W | Current beam scanline |
| blank | input | 1 | Beam is in the blank region |
| under_pix | input | COLOR_W | Underlying pixel color |
| out_pix | output | COLOR_W | Pixel after overlay, one cycle later |

## Verification
A wrong map pointer or plane offset shows up as a wrong foreground, background or transparent choice on the next pixel that reads the affected byte. The bench therefore loads the whole map with a computed pattern and compares many window positions against its own model, for both sizes and both display modes. A staging fault, where live geometry changes without frame_start, is visible one cycle after the write as a shifted cursor edge. The bench probes the edge columns and rows just inside and just outside the window, both before and after a frame pulse. Color and blank faults appear on the very next registered pixel.

// File: rtl/cursor_ovl_pkg.sv
`timescale 1ns/1ps
package cursor_ovl_pkg;

    typedef enum logic [2:0] {
        SEL_PTR  = 3'd0,
        SEL_DATA = 3'd1,
        SEL_XPOS = 3'd2,
        SEL_YPOS = 3'd3,
        SEL_CTRL = 3'd4,
        SEL_OVSC = 3'd5,
        SEL_BKGD = 3'd6,
        SEL_FGND = 3'd7
    } host_sel_e;

    typedef enum logic [1:0] {
        CM_OFF      = 2'd0,
        CM_OFF_ALT  = 2'd1,
        CM_UNDERLAY = 2'd2,
        CM_INVERT   = 2'd3
    } cur_mode_e;

    typedef enum logic {
        GEO_SYNCED  = 1'b0,
        GEO_PENDING = 1'b1
    } geo_state_e;

endpackage

// File: rtl/cursor_host_regs.sv
`timescale 1ns/1ps
module cursor_host_regs
    import cursor_ovl_pkg::*;
#(
    parameter int COLOR_W = 24,
    parameter int POS_W   = 12,
    parameter int AW      = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_we,
    input  logic [2:0]         host_sel,
    input  logic [COLOR_W-1:0] host_wdata,
    input  logic               frame_start,
    output logic               map_we,
    output logic [AW-1:0]      map_waddr,
    output logic [7:0]         map_wdata,
    output logic [POS_W-1:0]   live_x,
    output logic [POS_W-1:0]   live_y,
    output logic [1:0]         live_mode,
    output logic               live_big,
    output logic [COLOR_W-1:0] col_ovsc,
    output logic [COLOR_W-1:0] col_bkgd,
    output logic [COLOR_W-1:0] col_fgnd
);

    host_sel_e  sel;
    geo_state_e state_q, state_d;
    logic       geo_wr, commit;

    logic [AW-1:0]    ptr_q;
    logic [POS_W-1:0] stg_x_q, stg_y_q, live_x_q, live_y_q;
    logic [1:0]       stg_mode_q, live_mode_q;
    logic             stg_big_q, live_big_q;
    logic [COLOR_W-1:0] ovsc_q, bkgd_q, fgnd_q;

    assign sel    = host_sel_e'(host_sel);
    assign geo_wr = host_we && (sel inside {SEL_XPOS, SEL_YPOS, SEL_CTRL});
    assign commit = (state_q == GEO_PENDING) && frame_start;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= GEO_SYNCED;
        else     state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GEO_SYNCED:  if (geo_wr) state_d = GEO_PENDING;
            GEO_PENDING: if (frame_start && !geo_wr) state_d = GEO_SYNCED;
        endcase
    end

    // Register file and commit
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q       <= '0;
            stg_x_q     <= '0;
            stg_y_q     <= '0;
            stg_mode_q  <= '0;
            stg_big_q   <= 1'b0;
            live_x_q    <= '0;
            live_y_q    <= '0;
            live_mode_q <= '0;
            live_big_q  <= 1'b0;
            ovsc_q      <= '0;
            bkgd_q      <= '0;
            fgnd_q      <= '0;
        end else begin
            if (host_we) begin
                unique case (sel)
                    SEL_PTR:  ptr_q      <= host_wdata[AW-1:0];
                    SEL_DATA: ptr_q      <= ptr_q + 1'b1;
                    SEL_XPOS: stg_x_q    <= host_wdata[POS_W-1:0];
                    SEL_YPOS: stg_y_q    <= host_wdata[POS_W-1:0];
                    SEL_CTRL: begin
                        stg_mode_q <= host_wdata[1:0];
                        stg_big_q  <= host_wdata[2];
                    end
                    SEL_OVSC: ovsc_q     <= host_wdata;
                    SEL_BKGD: bkgd_q     <= host_wdata;
                    SEL_FGND: fgnd_q     <= host_wdata;
                endcase
            end
            if (commit) begin
                live_x_q    <= stg_x_q;
                live_y_q    <= stg_y_q;
                live_mode_q <= stg_mode_q;
                live_big_q  <= stg_big_q;
            end
        end
    end

    assign map_we    = host_we && (sel == SEL_DATA);
    assign map_waddr = ptr_q;
    assign map_wdata = host_wdata[7:0];
    assign live_x    = live_x_q;
    assign live_y    = live_y_q;
    assign live_mode = live_mode_q;
    assign live_big  = live_big_q;
    assign col_ovsc  = ovsc_q;
    assign col_bkgd  = bkgd_q;
    assign col_fgnd  = fgnd_q;

    // R2: every data write advances the pointer by one, wrapping
    a_r2_ptr_step: assert property (@(posedge clk) disable iff (rst)
        (host_we && sel == SEL_DATA) |=> ptr_q == AW'($past(ptr_q) + 1'b1));

    // R9: live geometry changes only on a commit edge
    a_r9_live_hold: assert property (@(posedge clk) disable iff (rst)
        !commit |=> ($stable(live_x_q) && $stable(live_y_q)
                     && $stable(live_mode_q) && $stable(live_big_q)));

    // R9: in the synced state staging and live copies agree
    a_r9_synced_match: assert property (@(posedge clk) disable iff (rst)
        (state_q == GEO_SYNCED) |-> (live_x_q == stg_x_q && live_y_q == stg_y_q
                                     && live_mode_q == stg_mode_q && live_big_q == stg_big_q));

endmodule

// File: rtl/cursor_map_ram.sv
`timescale 1ns/1ps
module cursor_map_ram #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr_img,
    input  logic [AW-1:0] raddr_shp,
    output logic [7:0]    rdata_img,
    output logic [7:0]    rdata_shp
);

    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata_img = mem[raddr_img];
    assign rdata_shp = mem[raddr_shp];

endmodule

// File: rtl/cursor_pixel_path.sv
`timescale 1ns/1ps
module cursor_pixel_path
    import cursor_ovl_pkg::*;
#(
    parameter int COLOR_W  = 24,
    parameter int POS_W    = 12,
    parameter int MAX_SIDE = 64,
    parameter int AW       = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [POS_W-1:0]   beam_x,
    input  logic [POS_W-1:0]   beam_y,
    input  logic               blank,
    input  logic [COLOR_W-1:0] under_pix,
    input  logic [POS_W-1:0]   live_x,
    input  logic [POS_W-1:0]   live_y,
    input  logic [1:0]         live_mode,
    input  logic               live_big,
    input  logic [COLOR_W-1:0] col_ovsc,
    input  logic [COLOR_W-1:0] col_bkgd,
    input  logic [COLOR_W-1:0] col_fgnd,
    output logic [AW-1:0]      img_addr,
    output logic [AW-1:0]      shp_addr,
    input  logic [7:0]         img_byte,
    input  logic [7:0]         shp_byte,
    output logic [COLOR_W-1:0] out_pix
);

    localparam int SIDE_W      = $clog2(MAX_SIDE);
    localparam int BPR_SH      = SIDE_W - 3;
    localparam int BIG_PLANE   = MAX_SIDE * MAX_SIDE / 8;
    localparam int SMALL_PLANE = BIG_PLANE / 4;

    logic [POS_W:0]      dx, dy, side;
    logic                in_win;
    logic [SIDE_W-1:0]   col, row;
    logic [AW-1:0]       idx;
    logic [2:0]          bsel;
    logic                img_bit, shp_bit;
    logic [COLOR_W-1:0]  nxt_pix, out_q;

    // Window test: distance from the bottom-right corner
    assign side   = live_big ? (POS_W+1)'(MAX_SIDE) : (POS_W+1)'(MAX_SIDE / 2);
    assign dx     = {1'b0, live_x} - {1'b0, beam_x};
    assign dy     = {1'b0, live_y} - {1'b0, beam_y};
    assign in_win = !dx[POS_W] && (dx < side) && !dy[POS_W] && (dy < side);

    // Column and row inside the cursor, counted from the top-left
    assign col = SIDE_W'(side - 1'b1 - dx);
    assign row = SIDE_W'(side - 1'b1 - dy);

    always_comb begin
        if (live_big) idx = (AW'(row) << BPR_SH)       | AW'(col >> 3);
        else          idx = (AW'(row) << (BPR_SH - 1)) | AW'(col >> 3);
    end

    assign img_addr = idx;
    assign shp_addr = idx + (live_big ? AW'(BIG_PLANE) : AW'(SMALL_PLANE));
    assign bsel     = ~col[2:0];
    assign img_bit  = img_byte[bsel];
    assign shp_bit  = shp_byte[bsel];

    // Output selection
    always_comb begin
        nxt_pix = under_pix;
        if (blank) begin
            nxt_pix = col_ovsc;
        end else if (in_win && shp_bit) begin
            unique case (cur_mode_e'(live_mode))
                CM_UNDERLAY: nxt_pix = img_bit ? col_fgnd : col_bkgd;
                CM_INVERT:   nxt_pix = img_bit ? col_fgnd : ~under_pix;
                default:     nxt_pix = under_pix;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= nxt_pix;
    end

    assign out_pix = out_q;

    // R8: blank forces overscan on the next output
    a_r8_blank_overscan: assert property (@(posedge clk) disable iff (rst)
        blank |=> out_pix == $past(col_ovsc));

    // R5: modes 0 and 1 pass the pixel through
    a_r5_off_passthru: assert property (@(posedge clk) disable iff (rst)
        (!blank && live_mode[1] == 1'b0) |=> out_pix == $past(under_pix));

    // R4: columns right of the cursor edge are untouched
    a_r4_right_of_edge: assert property (@(posedge clk) disable iff (rst)
        (!blank && beam_x > live_x) |=> out_pix == $past(under_pix));

    // R4: scanlines below the cursor edge are untouched
    a_r4_below_edge: assert property (@(posedge clk) disable iff (rst)
        (!blank && beam_y > live_y) |=> out_pix == $past(under_pix));

endmodule

// File: rtl/cursor_overlay.sv
`timescale 1ns/1ps
module cursor_overlay
    import cursor_ovl_pkg::*;
#(
    parameter int COLOR_W  = 24,
    parameter int POS_W    = 12,
    parameter int MAX_SIDE = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_we,
    input  logic [2:0]         host_sel,
    input  logic [COLOR_W-1:0] host_wdata,
    input  logic               frame_start,
    input  logic [POS_W-1:0]   beam_x,
    input  logic [POS_W-1:0]   beam_y,
    input  logic               blank,
    input  logic [COLOR_W-1:0] under_pix,
    output logic [COLOR_W-1:0] out_pix
);

    localparam int MAP_BYTES = MAX_SIDE * MAX_SIDE / 4;
    localparam int AW        = $clog2(MAP_BYTES);

    logic               map_we;
    logic [AW-1:0]      map_waddr, img_addr, shp_addr;
    logic [7:0]         map_wdata, img_byte, shp_byte;
    logic [POS_W-1:0]   live_x, live_y;
    logic [1:0]         live_mode;
    logic               live_big;
    logic [COLOR_W-1:0] col_ovsc, col_bkgd, col_fgnd;

    cursor_host_regs #(.COLOR_W(COLOR_W), .POS_W(POS_W), .AW(AW)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .host_we     (host_we),
        .host_sel    (host_sel),
        .host_wdata  (host_wdata),
        .frame_start (frame_start),
        .map_we      (map_we),
        .map_waddr   (map_waddr),
        .map_wdata   (map_wdata),
        .live_x      (live_x),
        .live_y      (live_y),
        .live_mode   (live_mode),
        .live_big    (live_big),
        .col_ovsc    (col_ovsc),
        .col_bkgd    (col_bkgd),
        .col_fgnd    (col_fgnd)
    );

    cursor_map_ram #(.AW(AW)) u_map (
        .clk       (clk),
        .we        (map_we),
        .waddr     (map_waddr),
        .wdata     (map_wdata),
        .raddr_img (img_addr),
        .raddr_shp (shp_addr),
        .rdata_img (img_byte),
        .rdata_shp (shp_byte)
    );

    cursor_pixel_path #(.COLOR_W(COLOR_W), .POS_W(POS_W), .MAX_SIDE(MAX_SIDE), .AW(AW)) u_pix (
        .clk       (clk),
        .rst       (rst),
        .beam_x    (beam_x),
        .beam_y    (beam_y),
        .blank     (blank),
        .under_pix (under_pix),
        .live_x    (live_x),
        .live_y    (live_y),
        .live_mode (live_mode),
        .live_big  (live_big),
        .col_ovsc  (col_ovsc),
        .col_bkgd  (col_bkgd),
        .col_fgnd  (col_fgnd),
        .img_addr  (img_addr),
        .shp_addr  (shp_addr),
        .img_byte  (img_byte),
        .shp_byte  (shp_byte),
        .out_pix   (out_pix)
    );

endmodule

// File: tb/cursor_overlay_tb.sv
`timescale 1ns/1ps
module cursor_overlay_tb;

    localparam int CW   = 24;
    localparam int PW   = 12;
    localparam int NV   = 12;
    localparam int XPOS = 100;
    localparam int YPOS = 80;

    // Stimulus vectors: offset left of xpos, offset above ypos, blank, pixel seed
    localparam int VDX [NV] = '{0, -1, 31, 32, 63, 64, 5, 17, 0, 40, 12, 3};
    localparam int VDY [NV] = '{0, 0, 0, 0, 5, 9, 31, 32, 63, 64, 7, 0};
    localparam bit VBL [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1};
    localparam logic [CW-1:0] VUN [NV] = '{24'h123456, 24'hABCDEF, 24'h0F0F0F, 24'h777777,
                                           24'h00FF00, 24'h808080, 24'h314159, 24'h271828,
                                           24'hC0FFEE, 24'h0000FF, 24'h5A5A5A, 24'hDEAD00};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_we = 1'b0;
    logic [2:0] host_sel = '0;
    logic [CW-1:0] host_wdata = '0;
    logic frame_start = 1'b0;
    logic [PW-1:0] beam_x = '0, beam_y = '0;
    logic blank = 1'b0;
    logic [CW-1:0] under_pix = '0;
    logic [CW-1:0] out_pix;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Bench model state
    logic [7:0] bmap [1024];
    int m_ptr = 0;
    int s_x = 0, s_y = 0, s_mode = 0, s_big = 0;
    int m_x = 0, m_y = 0, m_mode = 0, m_big = 0;
    logic [CW-1:0] m_c0 = '0, m_c1 = '0, m_c2 = '0;

    always #2 clk = ~clk;

    cursor_overlay #(.COLOR_W(CW), .POS_W(PW), .MAX_SIDE(64)) u_dut (
        .clk(clk), .rst(rst), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .frame_start(frame_start),
        .beam_x(beam_x), .beam_y(beam_y), .blank(blank),
        .under_pix(under_pix), .out_pix(out_pix)
    );

    function automatic logic [7:0] pat(int a);
        return 8'((a * 37 + (a >> 3) * 11 + 5) & 255);
    endfunction

    function automatic logic [CW-1:0] model(int x, int y, bit bl, logic [CW-1:0] und);
        int s, c, r, idx, b;
        bit im, sh;
        if (bl) return m_c0;
        if (m_mode < 2) return und;
        s = (m_big != 0) ? 64 : 32;
        if (!(x <= m_x && x > m_x - s && y <= m_y && y > m_y - s)) return und;
        c = s - 1 - (m_x - x);
        r = s - 1 - (m_y - y);
        idx = r * (s / 8) + c / 8;
        b = 7 - (c % 8);
        im = bmap[idx][b];
        sh = bmap[idx + s * s / 8][b];
        if (!sh) return und;
        if (im) return m_c2;
        return (m_mode == 2) ? m_c1 : ~und;
    endfunction

    task automatic chk(string req, logic [CW-1:0] act, logic [CW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(int sel, logic [CW-1:0] d);
        host_we = 1'b1;
        host_sel = 3'(sel);
        host_wdata = d;
        @(posedge clk);
        #1;
        host_we = 1'b0;
        case (sel)
            0: m_ptr = int'(d[9:0]);
            1: begin bmap[m_ptr] = d[7:0]; m_ptr = (m_ptr + 1) % 1024; end
            2: s_x = int'(d[PW-1:0]);
            3: s_y = int'(d[PW-1:0]);
            4: begin s_mode = int'(d[1:0]); s_big = int'(d[2]); end
            5: m_c0 = d;
            6: m_c1 = d;
            default: m_c2 = d;
        endcase
    endtask

    task automatic frame();
        frame_start = 1'b1;
        @(posedge clk);
        #1;
        frame_start = 1'b0;
        m_x = s_x; m_y = s_y; m_mode = s_mode; m_big = s_big;
    endtask

    task automatic px(string req, int x, int y, bit bl, logic [CW-1:0] und);
        logic [CW-1:0] exp;
        beam_x = PW'(x);
        beam_y = PW'(y);
        blank = bl;
        under_pix = und;
        exp = model(x, y, bl, und);
        @(posedge clk);
        #1;
        chk(req, out_pix, exp);
        blank = 1'b0;
    endtask

    task automatic walk(string req);
        for (int i = 0; i < NV; i++)
            px(req, XPOS - VDX[i], YPOS - VDY[i], VBL[i], VUN[i]);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0;
        // R1: reset output and passthrough with mode off
        chk("R1 reset out", out_pix, '0);
        px("R1 off after reset", 0, 0, 1'b0, 24'h4455AA);
        px("R1 overscan zero", 0, 0, 1'b1, 24'h4455AA);

        // R2/R3: fill whole map through the pointer port
        wr(0, 0);
        for (int a = 0; a < 1024; a++) wr(1, CW'(pat(a)));
        wr(5, 24'h102030);
        wr(6, 24'h0000AA);
        wr(7, 24'hFFEE00);
        wr(2, XPOS);
        wr(3, YPOS);
        wr(4, 24'd2);

        // R9: staged geometry invisible before frame_start
        chk("R9 pending mode", CW'(m_mode), '0);
        px("R9 before frame", XPOS - 3, YPOS - 3, 1'b0, 24'h111111);
        frame();

        walk("R6 mode2 size32");
        wr(4, 24'd3); frame();
        walk("R7 mode3 size32");
        wr(4, 24'd6); frame();
        walk("R3 mode2 size64");
        wr(4, 24'd7); frame();
        walk("R4 mode3 size64");
        wr(4, 24'd5); frame();
        walk("R5 mode1 off");

        // R9: x write without frame keeps old window, frame applies it
        wr(4, 24'd6); frame();
        wr(2, 300);
        px("R9 held", XPOS, YPOS, 1'b0, 24'h0A0B0C);
        frame();
        chk("R9 committed x", CW'(m_x), CW'(300));
        px("R9 applied", XPOS, YPOS, 1'b0, 24'h0A0B0C);
        wr(2, XPOS); frame();

        // R2: pointer wrap 1023 -> 0, explicit bytes
        wr(0, 1023);
        wr(1, 24'hFF);
        wr(1, 24'h80);
        wr(0, 511);
        wr(1, 24'h0F);
        wr(1, 24'h80);
        // R3: image row0 col0 from byte 0, shape from byte 512
        px("R2 wrap byte0", XPOS - 63, YPOS - 63, 1'b0, 24'h333333);
        chk("R2 fg literal", out_pix, 24'hFFEE00);
        px("R3 last col fg", XPOS, YPOS, 1'b0, 24'h333333);
        chk("R3 fg literal", out_pix, 24'hFFEE00);
        px("R6 bg pixel", XPOS - 7, YPOS, 1'b0, 24'h333333);
        chk("R6 bg literal", out_pix, 24'h0000AA);

        // R10: color write effective on next pixel
        wr(6, 24'h654321);
        px("R10 new bg", XPOS - 7, YPOS, 1'b0, 24'h333333);
        chk("R10 bg literal", out_pix, 24'h654321);
        wr(4, 24'd7); frame();
        px("R7 inverted", XPOS - 7, YPOS, 1'b0, 24'h333333);
        chk("R7 invert literal", out_pix, 24'hCCCCCC);

        // R8: blank overrides cursor and outside pixels
        wr(5, 24'hA1B2C3);
        px("R8 blank in cursor", XPOS, YPOS, 1'b1, 24'h333333);
        px("R8 blank outside", 0, 0, 1'b1, 24'h333333);
        chk("R8 ovsc literal", out_pix, 24'hA1B2C3);

        // R4: window edges at size 64
        px("R4 left edge out", XPOS - 64, YPOS, 1'b0, 24'h999999);
        chk("R4 out literal", out_pix, 24'h999999);
        px("R4 top edge out", XPOS, YPOS - 64, 1'b0, 24'h999999);
        chk("R4 top literal", out_pix, 24'h999999);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule